// File: doc/BRIEF.md
# Register Scoreboard Hazard Interlock

This block sits at the register-access stage of an in-order pipeline. It keeps one pending-write flag for each architectural register. Each flag marks a register whose new value is still being computed. An instruction arriving in the register-access stage names up to two source registers and one destination register, and each field has its own valid bit. The block compares these fields with the flags. If a source is still awaited, the instruction would read a stale value. If the destination is still awaited, two writes to the same register could land in the wrong order. In either case the block holds the instruction where it is and sends a bubble (a NOP slot) down the pipeline in its place.

Three completion ports report results as they are produced. Port 0 carries single-cycle integer results from execution stage one. Port 1 carries results from stage two. Port 2 carries long-latency floating-point results from stage four. Each report clears the flag of the named register. The clears take effect before the hazard checks in the same cycle, so a register that is freed this cycle causes no stall. When an instruction issues with a valid destination, the flag of that destination is set on the next clock edge. Reads alone never set a flag.

Top module: `hazard_interlock`

## Requirements
- R1: Reset clears all flags. After reset, an instruction that reads any pair of registers issues without stalling.
- R2: If `ra_valid` is 1 and a source field with its valid bit at 1 names a flagged register, the outputs are `stall`=1, `issue`=0 and `bubble`=1 in that same cycle.
- R3: If `ra_valid` is 1, `dst_vld` is 1 and `dst_idx` names a flagged register, the outputs are `stall`=1, `issue`=0 and `bubble`=1.
- R4: An issue with `dst_vld`=1 sets the flag of `dst_idx` on the next edge. An instruction whose destination field is not valid sets no flag, so consecutive reads of one register never stall.
- R5: A completion on port 0 (stage one), port 1 (stage two) or port 2 (stage four) clears the flag of its register. The checks in that same cycle already see the register as free.
- R6: If a completion clears a register and an issuing instruction sets the same register in the same cycle, the set wins and the flag stays pending.
- R7: A source or destination field whose valid bit is 0 takes no part in the checks, whatever register it names.
- R8: `issue` = `ra_valid` with no hazard. `stall` = `ra_valid` with a hazard. `bubble` = 1 in every cycle without an issue, including cycles with `ra_valid`=0.
- R9: The stall penalties below hold, with completions at one cycle (integer), two cycles (mid-latency) and four cycles (floating-point) after issue.
  - Dependent integer after integer: 0 stall cycles.
  - After a mid-latency result: 1 stall cycle.
  - After a floating-point result: 3 stall cycles.
  - For a random back-to-back mix, the total stall count matches a reference model.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ra_valid | input | 1 | An instruction is present in register access |
| src0_idx | input | IDX_W | First source register |
| src0_vld | input | 1 | First source field is in use |
| src1_idx | input | IDX_W | Second source register |
| src1_vld | input | 1 | Second source field is in use |
| dst_idx | input | IDX_W | Destination register |
| dst_vld | input | 1 | Destination field is in use |
| cpl_vld | input | NUM_CPL | Completion strobe per port (0: stage one, 1: stage two, 2: stage four) |
| cpl_idx | input | NUM_CPL x IDX_W | Completed destination register per port |
| stall | output | 1 | Hold the instruction in register access |
| bubble | output | 1 | Insert a NOP downstream this cycle |
| issue | output | 1 | The instruction leaves register access this cycle |

## Verification
The assertions assume two things about the inputs:
- A completion names only a register whose flag is set.
- No two completion ports name the same register in one cycle.

Together these mean each pending write is retired exactly once. The bench keeps within this contract. It raises completions only from its own schedule of issued writes, at the fixed latency of each instruction class. Because the write-after-write interlock allows at most one outstanding writer per register, two ports can never report the same register at once. While `stall` is high, the bench holds the stalled instruction's fields steady.

// File: rtl/hzd_pkg.sv
package hzd_pkg;

    localparam int HZD_NUM_REGS = 64;
    localparam int HZD_NUM_CPL  = 3;

    // Completion ports, ordered by execution stage.
    typedef enum int {
        CPL_STAGE1 = 0,
        CPL_STAGE2 = 1,
        CPL_STAGE4 = 2
    } cpl_port_e;

endpackage

// File: rtl/hzd_onehot.sv
module hzd_onehot #(
    parameter int N = 64,
    localparam int W = $clog2(N)
) (
    input  logic [W-1:0] idx,
    input  logic         en,
    output logic [N-1:0] mask
);
    always_comb begin
        mask = '0;
        if (en) mask[idx] = 1'b1;
    end
endmodule

// File: rtl/hzd_clear_mask.sv
module hzd_clear_mask #(
    parameter int NUM_REGS = 64,
    parameter int NUM_CPL  = 3,
    localparam int IDX_W   = $clog2(NUM_REGS)
) (
    input  logic [NUM_CPL-1:0]            cpl_vld,
    input  logic [NUM_CPL-1:0][IDX_W-1:0] cpl_idx,
    output logic [NUM_REGS-1:0]           clr_mask
);
    logic [NUM_CPL-1:0][NUM_REGS-1:0] port_mask;

    for (genvar p = 0; p < NUM_CPL; p++) begin : g_port
        hzd_onehot #(.N(NUM_REGS)) u_dec (
            .idx  (cpl_idx[p]),
            .en   (cpl_vld[p]),
            .mask (port_mask[p])
        );
    end

    always_comb begin
        clr_mask = '0;
        for (int p = 0; p < NUM_CPL; p++) clr_mask |= port_mask[p];
    end
endmodule

// File: rtl/hzd_check.sv
module hzd_check #(
    parameter int NUM_REGS = 64,
    localparam int IDX_W   = $clog2(NUM_REGS)
) (
    input  logic [NUM_REGS-1:0] flags,
    input  logic [IDX_W-1:0]    src0_idx,
    input  logic                src0_vld,
    input  logic [IDX_W-1:0]    src1_idx,
    input  logic                src1_vld,
    input  logic [IDX_W-1:0]    dst_idx,
    input  logic                dst_vld,
    output logic                raw_hit,
    output logic                waw_hit
);
    always_comb begin
        raw_hit = (src0_vld && flags[src0_idx]) || (src1_vld && flags[src1_idx]);
        waw_hit = dst_vld && flags[dst_idx];
    end
endmodule

// File: rtl/hazard_interlock.sv
module hazard_interlock
    import hzd_pkg::*;
#(
    parameter int NUM_REGS = HZD_NUM_REGS,
    parameter int NUM_CPL  = HZD_NUM_CPL,
    localparam int IDX_W   = $clog2(NUM_REGS)
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          ra_valid,
    input  logic [IDX_W-1:0]              src0_idx,
    input  logic                          src0_vld,
    input  logic [IDX_W-1:0]              src1_idx,
    input  logic                          src1_vld,
    input  logic [IDX_W-1:0]              dst_idx,
    input  logic                          dst_vld,
    input  logic [NUM_CPL-1:0]            cpl_vld,
    input  logic [NUM_CPL-1:0][IDX_W-1:0] cpl_idx,
    output logic                          stall,
    output logic                          bubble,
    output logic                          issue
);
    typedef struct packed {
        logic [NUM_REGS-1:0] pend;
    } sb_state_t;

    sb_state_t           st_q, st_d;
    logic [NUM_REGS-1:0] clr_mask;
    logic [NUM_REGS-1:0] pend_live;
    logic [NUM_REGS-1:0] set_mask;
    logic                raw_hit, waw_hit;
    logic                issue_w;

    hzd_clear_mask #(.NUM_REGS(NUM_REGS), .NUM_CPL(NUM_CPL)) u_clr (
        .cpl_vld  (cpl_vld),
        .cpl_idx  (cpl_idx),
        .clr_mask (clr_mask)
    );

    // Completions retire before the checks look at the flags.
    assign pend_live = st_q.pend & ~clr_mask;

    hzd_check #(.NUM_REGS(NUM_REGS)) u_chk (
        .flags    (pend_live),
        .src0_idx (src0_idx),
        .src0_vld (src0_vld),
        .src1_idx (src1_idx),
        .src1_vld (src1_vld),
        .dst_idx  (dst_idx),
        .dst_vld  (dst_vld),
        .raw_hit  (raw_hit),
        .waw_hit  (waw_hit)
    );

    assign issue_w = ra_valid && !(raw_hit || waw_hit);

    hzd_onehot #(.N(NUM_REGS)) u_set (
        .idx  (dst_idx),
        .en   (issue_w && dst_vld),
        .mask (set_mask)
    );

    always_comb begin
        st_d      = st_q;
        st_d.pend = pend_live | set_mask;   // set applied after clear: set wins
        issue     = issue_w;
        stall     = ra_valid && !issue_w;
        bubble    = !issue_w;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end
endmodule

// File: rtl/hzd_interlock_chk.sv
module hzd_interlock_chk #(
    parameter int NUM_REGS = 64,
    parameter int NUM_CPL  = 3,
    localparam int IDX_W   = $clog2(NUM_REGS)
) (
    input logic                          clk,
    input logic                          rst_n,
    input logic                          ra_valid,
    input logic [IDX_W-1:0]              src0_idx,
    input logic                          src0_vld,
    input logic [IDX_W-1:0]              src1_idx,
    input logic                          src1_vld,
    input logic [IDX_W-1:0]              dst_idx,
    input logic                          dst_vld,
    input logic [NUM_CPL-1:0]            cpl_vld,
    input logic [NUM_CPL-1:0][IDX_W-1:0] cpl_idx,
    input logic                          stall,
    input logic                          bubble,
    input logic                          issue,
    input logic [NUM_REGS-1:0]           pend_q
);
    // R1
    reset_clear_chk: assert property (@(posedge clk)
        !rst_n |=> (pend_q == '0));

    // R4
    set_on_issue_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (issue && dst_vld) |=> pend_q[$past(dst_idx)]);

    // R4
    no_spurious_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(issue && dst_vld) |=> ($countones(pend_q) <= $past($countones(pend_q))));

    // R2 R3
    stall_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stall |-> ((src0_vld && pend_q[src0_idx]) || (src1_vld && pend_q[src1_idx])
                   || (dst_vld && pend_q[dst_idx])));

    // R8
    idle_bubble_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !ra_valid |-> (!issue && !stall && bubble));

    for (genvar k = 0; k < NUM_CPL; k++) begin : g_cpl
        // R5
        cpl_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (cpl_vld[k] && !(issue && dst_vld && dst_idx == cpl_idx[k]))
            |=> !pend_q[$past(cpl_idx[k])]);

        // R5 (input contract: only pending registers complete)
        cpl_pending_in_chk: assert property (@(posedge clk) disable iff (!rst_n)
            cpl_vld[k] |-> pend_q[cpl_idx[k]]);
    end
endmodule

bind hazard_interlock hzd_interlock_chk #(.NUM_REGS(NUM_REGS), .NUM_CPL(NUM_CPL)) u_sva (
    .clk      (clk),
    .rst_n    (rst_n),
    .ra_valid (ra_valid),
    .src0_idx (src0_idx),
    .src0_vld (src0_vld),
    .src1_idx (src1_idx),
    .src1_vld (src1_vld),
    .dst_idx  (dst_idx),
    .dst_vld  (dst_vld),
    .cpl_vld  (cpl_vld),
    .cpl_idx  (cpl_idx),
    .stall    (stall),
    .bubble   (bubble),
    .issue    (issue),
    .pend_q   (st_q.pend)
);

// File: tb/hazard_interlock_tb_top.sv
`timescale 1ns/1ps
module hazard_interlock_tb_top;
    localparam int NR = 64;
    localparam int NC = 3;
    localparam int IW = $clog2(NR);

    logic                  clk = 1'b0;
    logic                  rst_n;
    logic                  ra_valid;
    logic [IW-1:0]         src0_idx, src1_idx, dst_idx;
    logic                  src0_vld, src1_vld, dst_vld;
    logic [NC-1:0]         cpl_vld;
    logic [NC-1:0][IW-1:0] cpl_idx;
    logic                  stall, bubble, issue;

    always #2 clk = ~clk;   // 250 MHz

    hazard_interlock dut_i (
        .clk(clk), .rst_n(rst_n), .ra_valid(ra_valid),
        .src0_idx(src0_idx), .src0_vld(src0_vld),
        .src1_idx(src1_idx), .src1_vld(src1_vld),
        .dst_idx(dst_idx), .dst_vld(dst_vld),
        .cpl_vld(cpl_vld), .cpl_idx(cpl_idx),
        .stall(stall), .bubble(bubble), .issue(issue)
    );

    typedef struct {
        bit nop;
        int s0, s1, d;
        bit v0, v1, vd;
        int lat;   // 1, 2 or 4 cycles to completion
    } instr_t;

    typedef struct {
        int cyc;
        int port;
        int idx;
    } due_t;

    instr_t prog[$];
    due_t   dues[$];
    bit     mpend[NR];
    int     cyc = 0;
    int     checks = 0;
    int     errors = 0;
    int     dut_stalls = 0;
    int     mod_stalls = 0;

    task automatic check(bit ok, string req, string what, int act, int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d (cycle %0d)", req, what, act, exp, cyc);
        end
    endtask

    function automatic instr_t mk(int s0, bit v0, int s1, bit v1, int d, bit vd, int lat);
        instr_t i;
        i.nop = 1'b0; i.s0 = s0; i.v0 = v0; i.s1 = s1; i.v1 = v1;
        i.d = d; i.vd = vd; i.lat = lat;
        return i;
    endfunction

    function automatic instr_t idle();
        instr_t i = mk(0, 0, 0, 0, 0, 0, 1);
        i.nop = 1'b1;
        return i;
    endfunction

    // One clock: drive after the edge, compare with the model before the next edge.
    task automatic step();
        bit     live[NR];
        bit     valid, raw, waw, e_issue, e_stall, e_bub;
        instr_t cur;
        string  tag;
        due_t   keep[$];
        cpl_vld = '0;
        cpl_idx = '0;
        foreach (dues[n]) begin
            if (dues[n].cyc == cyc) begin
                cpl_vld[dues[n].port] = 1'b1;
                cpl_idx[dues[n].port] = IW'(dues[n].idx);
            end else begin
                keep.push_back(dues[n]);
            end
        end
        cur = (prog.size() > 0) ? prog[0] : idle();
        valid    = !cur.nop;
        ra_valid = valid;
        src0_idx = IW'(cur.s0); src0_vld = cur.v0;
        src1_idx = IW'(cur.s1); src1_vld = cur.v1;
        dst_idx  = IW'(cur.d);  dst_vld  = cur.vd;
        #2;
        live = mpend;
        foreach (dues[n]) if (dues[n].cyc == cyc) live[dues[n].idx] = 1'b0;
        raw = (cur.v0 && live[cur.s0]) || (cur.v1 && live[cur.s1]);
        waw = cur.vd && live[cur.d];
        e_issue = valid && !raw && !waw;
        e_stall = valid && (raw || waw);
        e_bub   = !e_issue;
        tag = !valid ? "R8" : raw ? "R2" : waw ? "R3" : "R5";
        check(stall == e_stall, tag, "stall", int'(stall), int'(e_stall));
        check(issue == e_issue, tag, "issue", int'(issue), int'(e_issue));
        check(bubble == e_bub, "R8", "bubble", int'(bubble), int'(e_bub));
        if (stall) dut_stalls++;
        if (e_stall) mod_stalls++;
        dues = keep;
        if (e_issue && cur.vd) begin
            due_t nd;
            live[cur.d] = 1'b1;
            nd.cyc  = cyc + cur.lat;
            nd.port = (cur.lat == 1) ? 0 : (cur.lat == 2) ? 1 : 2;
            nd.idx  = cur.d;
            dues.push_back(nd);
        end
        mpend = live;
        if (prog.size() > 0 && (cur.nop || e_issue)) void'(prog.pop_front());
        @(posedge clk);
        #1;
        cyc++;
    endtask

    task automatic run_seq(string req, string name, int exp_stalls);
        int start = dut_stalls;
        int guard = 0;
        while (prog.size() > 0 && guard < 5000) begin
            step();
            guard++;
        end
        for (int k = 0; k < 6; k++) step();
        if (exp_stalls >= 0)
            check((dut_stalls - start) == exp_stalls, req, name, dut_stalls - start, exp_stalls);
    endtask

    initial begin
        #(4ns * 200000);
        checks++;
        errors++;
        $display("FAIL watchdog expired actual=%0d expected=0", cyc);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        rst_n = 1'b0;
        ra_valid = 1'b0;
        src0_idx = '0; src1_idx = '0; dst_idx = '0;
        src0_vld = 1'b0; src1_vld = 1'b0; dst_vld = 1'b0;
        cpl_vld = '0; cpl_idx = '0;
        foreach (mpend[r]) mpend[r] = 1'b0;
        repeat (3) @(posedge clk);
        #1;
        rst_n = 1'b1;
        // Reset state with nothing in register access: no issue, bubble set.
        #1;
        check(stall == 1'b0 && issue == 1'b0, "R8", "reset idle issue/stall",
              int'({issue, stall}), 0);
        check(bubble == 1'b1, "R1", "reset bubble", int'(bubble), 1);
        #0;
        @(negedge clk);
        @(posedge clk);
        #1;

        // R1: every register reads free after reset
        for (int r = 0; r < NR; r++) prog.push_back(mk(r, 1, NR - 1 - r, 1, 0, 0, 1));
        run_seq("R1", "reads after reset stall count", 0);

        // R9/R5: integer producer then integer consumer
        prog.push_back(mk(0, 0, 0, 0, 1, 1, 1));
        prog.push_back(mk(1, 1, 0, 0, 2, 1, 1));
        run_seq("R9", "int->int stall count", 0);

        // R2/R9: floating-point producer then dependent integer
        prog.push_back(mk(0, 0, 0, 0, 3, 1, 4));
        prog.push_back(mk(3, 1, 0, 0, 4, 1, 1));
        run_seq("R2", "fp->int RAW stall count", 3);

        // R5/R9: mid-latency producer, consumer on second source
        prog.push_back(mk(0, 0, 0, 0, 12, 1, 2));
        prog.push_back(mk(5, 1, 12, 1, 13, 1, 1));
        run_seq("R5", "stage-two result stall count", 1);

        // R3 + R6: WAW stalls until the clear; same-cycle set must keep r10 pending
        prog.push_back(mk(0, 0, 0, 0, 10, 1, 4));
        prog.push_back(mk(0, 0, 0, 0, 10, 1, 4));
        prog.push_back(mk(10, 1, 0, 0, 0, 0, 1));
        run_seq("R6", "WAW then set-wins stall count", 6);

        // R4: reads never set a flag (read-after-read, then a write to the read register)
        prog.push_back(mk(7, 1, 0, 0, 0, 0, 1));
        prog.push_back(mk(7, 1, 7, 1, 0, 0, 1));
        prog.push_back(mk(0, 0, 0, 0, 7, 1, 1));
        run_seq("R4", "read-after-read stall count", 0);

        // R7 + R8: invalid fields naming a pending register, and idle slots
        prog.push_back(mk(0, 0, 0, 0, 9, 1, 4));
        prog.push_back(mk(9, 0, 9, 0, 9, 0, 1));
        prog.push_back(idle());
        prog.push_back(idle());
        prog.push_back(mk(9, 0, 9, 0, 9, 0, 1));
        run_seq("R7", "invalid fields stall count", 0);

        // R9: random back-to-back mix against the model's total
        begin
            int start_m = mod_stalls;
            int start_d = dut_stalls;
            for (int n = 0; n < 300; n++) begin
                int sel = int'($urandom_range(0, 2));
                int lat = (sel == 0) ? 1 : (sel == 1) ? 2 : 4;
                prog.push_back(mk(int'($urandom_range(0, 7)), 1'($urandom_range(0, 1)),
                                  int'($urandom_range(0, 7)), 1'($urandom_range(0, 1)),
                                  int'($urandom_range(0, 7)), 1'($urandom_range(0, 1)), lat));
            end
            run_seq("R9", "random mix", -1);
            check((dut_stalls - start_d) == (mod_stalls - start_m), "R9", "random mix stall total",
                  dut_stalls - start_d, mod_stalls - start_m);
        end

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule